// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block turns a system clock into the bus timing of an I2C master. A sequencer hands it one command at a time: START, BIT, RESTART or STOP. The block then runs through that command's phases. It holds the desired SCL level and emits single-cycle strobes that tell the sequencer when to pull SDA low, release SDA, place the next data bit and sample SDA. Every phase length comes from packed timing words. A prescaler divides the clock into ticks of DIV+1 clocks, and phase counts are measured in those ticks.

There are two sets of timing words, one for fast mode and one for high-speed mode. A data-hold word is shared by both sets, as is the filter-cycle count. The mode input is captured when a command is accepted. A high-speed transfer can therefore begin at fast timing and switch sets at a command boundary. Each rising SCL edge is followed by a wait of 8 + 2×FILTER raw clocks for synchronisation and filtering. As a result, a bit lasts (DIV+1)×(SCL_L+SCL_H+2) + 8 + 2×FILTER clocks.

Top module: `i2c_timing_gen`

## Requirements
- R1: After reset, `scl_o` is 1, `cmd_ready` is 1 and every strobe output is 0.
- R2: A tick lasts DIV+1 clocks. Word 3 bits 23:16 hold DIV. Word 1 bits 31:24 hold START setup, bits 23:16 hold START hold and bits 15:8 hold STOP setup. A START (cmd 0) pulses `sda_low_stb` in the cycle after acceptance. After START-hold ticks, `scl_o` falls and `done_stb` pulses.
- R3: For a BIT (cmd 1) whose SCL low count covers data hold plus data setup, the time from acceptance to `done_stb` is (DIV+1)×(SCL_L+SCL_H+2)+8+2×FILTER clocks. Word 2 bits 15:8 hold SCL_L and bits 7:0 hold SCL_H.
- R4: In a BIT, `data_stb` pulses while SCL is low, data-hold ticks after acceptance. Data hold is the shared word, bits 7:0. SCL then rises. `sample_stb` pulses 8+2×FILTER clocks later, and SCL stays high for SCL_H+1 ticks.
- R5: A setup, hold or release count of zero is timed as one tick.
- R6: The SCL low part of a BIT lasts max(SCL_L+1, hold+setup) ticks. Data setup is word 2 bits 31:24.
- R7: A RESTART (cmd 2) first pulses `sda_rel_stb`. After release ticks (word 3 bits 7:0), SCL rises. After the rise wait plus START-setup ticks, `sda_low_stb` pulses. After START-hold ticks, SCL falls and `done_stb` pulses.
- R8: A STOP (cmd 3) first pulses `sda_low_stb`. SCL rises after SCL_L+1 ticks. After the rise wait plus STOP-setup ticks, `sda_rel_stb` and `done_stb` pulse together, and SCL stays high.
- R9: `mode_hs` = 1 selects the high-speed words and 0 selects the fast words. The value is taken when the command is accepted, and changing it mid-command has no effect.
- R10: While `cmd_ready` is 0, `cmd_valid` is ignored.
- R11: At most one SDA strobe is active at a time. `sample_stb` occurs only with SCL high and `data_stb` only with SCL low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_hs | input | 1 | Timing set select, 1 = high speed |
| cmd_valid | input | 1 | Command request |
| cmd | input | 2 | 0 START, 1 BIT, 2 RESTART, 3 STOP |
| fs_word1 | input | 32 | Fast START/STOP timing word |
| fs_word2 | input | 32 | Fast data setup and SCL low/high word |
| fs_word3 | input | 32 | Fast divider and release word |
| hs_word1 | input | 32 | High-speed START/STOP timing word |
| hs_word2 | input | 32 | High-speed data setup and SCL low/high word |
| hs_word3 | input | 32 | High-speed divider and release word |
| hold_word | input | 32 | Shared data hold word |
| filt_cycles | input | 3 | Input filter cycles |
| cmd_ready | output | 1 | Idle and able to accept a command |
| scl_o | output | 1 | Desired SCL level, 1 = released |
| sda_low_stb | output | 1 | Pull SDA low now |
| sda_rel_stb | output | 1 | Release SDA now |
| data_stb | output | 1 | Place next data bit on SDA |
| sample_stb | output | 1 | Sample SDA now |
| done_stb | output | 1 | Command finished |

## Verification
The assertions check the following on every cycle:
- the SDA strobes never overlap;
- sampling happens only with SCL released, and data is placed only with SCL low;
- completion coincides with readiness;
- the latched mode holds while busy;
- the prescaler never passes its divider.

The exact clock count of each phase needs the bench's scenarios to show it. So does every behaviour listed here:
- the bit period formula;
- the zero-count and low-stretch rules;
- the choice between word sets, and the latching of the mode;
- the refusal of commands while busy.

// File: rtl/i2c_timing_gen.sv
module i2c_timing_gen #(
  parameter int OVH_BASE = 8,
  parameter int FLT_W    = 3,
  parameter int CW       = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_hs,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd,
  input  logic [31:0]      fs_word1,
  input  logic [31:0]      fs_word2,
  input  logic [31:0]      fs_word3,
  input  logic [31:0]      hs_word1,
  input  logic [31:0]      hs_word2,
  input  logic [31:0]      hs_word3,
  input  logic [31:0]      hold_word,
  input  logic [FLT_W-1:0] filt_cycles,
  output logic             cmd_ready,
  output logic             scl_o,
  output logic             sda_low_stb,
  output logic             sda_rel_stb,
  output logic             data_stb,
  output logic             sample_stb,
  output logic             done_stb
);

  typedef enum logic [3:0] {
    S_IDLE, S_STA_HD, S_BIT_HD, S_BIT_LO, S_BIT_RISE, S_BIT_HI,
    S_RS_LO, S_RS_RISE, S_RS_SU, S_SP_LO, S_SP_RISE, S_SP_SU
  } st_t;

  st_t           state;
  logic          hs_q;
  logic [7:0]    pre;
  logic [CW-1:0] cnt, len, lo_len, hi_len, ehd, esu, lo_rest, ovh;
  logic          raw, step, last;

  function automatic logic [CW-1:0] min1(input logic [7:0] v);
    return (v == 8'd0) ? CW'(1) : CW'(v);
  endfunction

  wire [31:0] w1 = hs_q ? hs_word1 : fs_word1;
  wire [31:0] w2 = hs_q ? hs_word2 : fs_word2;
  wire [31:0] w3 = hs_q ? hs_word3 : fs_word3;
  wire [7:0]  div = w3[23:16];
  wire        unused_fields = ^{w1[7:0], w2[23:16], w3[31:24], w3[15:8], hold_word[31:8]};

  assign lo_len  = CW'(w2[15:8]) + CW'(1);
  assign hi_len  = CW'(w2[7:0]) + CW'(1);
  assign ehd     = min1(hold_word[7:0]);
  assign esu     = min1(w2[31:24]);
  assign lo_rest = (lo_len > ehd && (lo_len - ehd) > esu) ? lo_len - ehd : esu;
  assign ovh     = CW'(OVH_BASE) + CW'({filt_cycles, 1'b0});

  always_comb begin
    case (state)
      S_STA_HD:                          len = min1(w1[23:16]);
      S_BIT_HD:                          len = ehd;
      S_BIT_LO:                          len = lo_rest;
      S_BIT_HI:                          len = hi_len;
      S_RS_LO:                           len = min1(w3[7:0]);
      S_RS_SU:                           len = min1(w1[31:24]);
      S_SP_LO:                           len = lo_len;
      S_SP_SU:                           len = min1(w1[15:8]);
      default:                           len = ovh;
    endcase
  end

  assign raw       = state inside {S_BIT_RISE, S_RS_RISE, S_SP_RISE};
  assign step      = raw || (pre == div);
  assign last      = step && (cnt + CW'(1) == len);
  assign cmd_ready = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; hs_q <= 1'b0; pre <= '0; cnt <= '0; scl_o <= 1'b1;
      sda_low_stb <= 1'b0; sda_rel_stb <= 1'b0; data_stb <= 1'b0;
      sample_stb <= 1'b0; done_stb <= 1'b0;
    end else begin
      sda_low_stb <= 1'b0; sda_rel_stb <= 1'b0; data_stb <= 1'b0;
      sample_stb <= 1'b0; done_stb <= 1'b0;
      if (state == S_IDLE) begin
        if (cmd_valid) begin
          hs_q <= mode_hs; pre <= '0; cnt <= '0;
          case (cmd)
            2'd0: begin sda_low_stb <= 1'b1; state <= S_STA_HD; end
            2'd1: state <= S_BIT_HD;
            2'd2: begin sda_rel_stb <= 1'b1; state <= S_RS_LO; end
            default: begin sda_low_stb <= 1'b1; state <= S_SP_LO; end
          endcase
        end
      end else if (last) begin
        pre <= '0; cnt <= '0;
        case (state)
          S_STA_HD:   begin scl_o <= 1'b0; done_stb <= 1'b1; state <= S_IDLE; end
          S_BIT_HD:   begin data_stb <= 1'b1; state <= S_BIT_LO; end
          S_BIT_LO:   begin scl_o <= 1'b1; state <= S_BIT_RISE; end
          S_BIT_RISE: begin sample_stb <= 1'b1; state <= S_BIT_HI; end
          S_BIT_HI:   begin scl_o <= 1'b0; done_stb <= 1'b1; state <= S_IDLE; end
          S_RS_LO:    begin scl_o <= 1'b1; state <= S_RS_RISE; end
          S_RS_RISE:  state <= S_RS_SU;
          S_RS_SU:    begin sda_low_stb <= 1'b1; state <= S_STA_HD; end
          S_SP_LO:    begin scl_o <= 1'b1; state <= S_SP_RISE; end
          S_SP_RISE:  state <= S_SP_SU;
          default:    begin sda_rel_stb <= 1'b1; done_stb <= 1'b1; state <= S_IDLE; end
        endcase
      end else if (raw) begin
        cnt <= cnt + CW'(1);
      end else if (step) begin
        pre <= '0; cnt <= cnt + CW'(1);
      end else begin
        pre <= pre + 8'd1;
      end
    end
  end

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sda_low_stb, sda_rel_stb, data_stb, sample_stb}));
  assert_sample_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> scl_o);
  assert_data_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_stb |-> !scl_o);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_stb |-> cmd_ready);
  assert_mode_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> $stable(hs_q));
  assert_pre_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pre <= div);

endmodule

// File: tb/i2c_timing_gen_bench.sv
`timescale 1ns/1ps
module i2c_timing_gen_bench;
  localparam int K_SLOW = 0, K_SREL = 1, K_DATA = 2, K_SAMP = 3,
                 K_RISE = 4, K_FALL = 5, K_DONE = 6;

  typedef struct { int cyc; int kind; string req; } ev_t;
  typedef struct { int div, shd, ssu, psu, dsu, l, h, rel; } tcfg_t;

  logic clk = 0, rst_n = 0, mode_hs = 0, cmd_valid = 0;
  logic [1:0] cmd = 0;
  logic [31:0] fs_word1, fs_word2, fs_word3, hs_word1, hs_word2, hs_word3, hold_word;
  logic [2:0] filt_cycles;
  logic cmd_ready, scl_o, sda_low_stb, sda_rel_stb, data_stb, sample_stb, done_stb;

  ev_t q[$];
  tcfg_t fs, hs;
  int hd, flt, cyc = 0, nchk = 0, nfail = 0;
  bit mon_en = 0, prev_scl = 1;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_timing_gen u_i2c_timing_gen (
    .clk(clk), .rst_n(rst_n), .mode_hs(mode_hs), .cmd_valid(cmd_valid), .cmd(cmd),
    .fs_word1(fs_word1), .fs_word2(fs_word2), .fs_word3(fs_word3),
    .hs_word1(hs_word1), .hs_word2(hs_word2), .hs_word3(hs_word3),
    .hold_word(hold_word), .filt_cycles(filt_cycles), .cmd_ready(cmd_ready),
    .scl_o(scl_o), .sda_low_stb(sda_low_stb), .sda_rel_stb(sda_rel_stb),
    .data_stb(data_stb), .sample_stb(sample_stb), .done_stb(done_stb));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int ex(input int v); return (v == 0) ? 1 : v; endfunction

  task automatic push(input int c, input int k, input string r);
    ev_t e; e.cyc = c; e.kind = k; e.req = r; q.push_back(e);
  endtask

  task automatic apply();
    fs_word1 = {8'(fs.ssu), 8'(fs.shd), 8'(fs.psu), 8'h5A};
    fs_word2 = {8'(fs.dsu), 8'h5A, 8'(fs.l), 8'(fs.h)};
    fs_word3 = {8'h5A, 8'(fs.div), 8'h5A, 8'(fs.rel)};
    hs_word1 = {8'(hs.ssu), 8'(hs.shd), 8'(hs.psu), 8'hA5};
    hs_word2 = {8'(hs.dsu), 8'hA5, 8'(hs.l), 8'(hs.h)};
    hs_word3 = {8'hA5, 8'(hs.div), 8'hA5, 8'(hs.rel)};
    hold_word = {24'h5A5A5A, 8'(hd)};
    filt_cycles = 3'(flt);
  endtask

  // Driver: predicts every event from the requirements, then issues the command.
  task automatic issue(input int c, input bit md, input bit flip, input bit poke, input string r);
    tcfg_t s; int t, ov, a, x, low;
    s = md ? hs : fs; t = s.div + 1; ov = 8 + 2 * flt; a = cyc + 1;
    case (c)
      0: begin // R2 START
        push(a, K_SLOW, r); x = a + ex(s.shd) * t;
        push(x, K_FALL, r); push(x, K_DONE, r);
      end
      1: begin // R3 R4 R6 BIT
        x = a + ex(hd) * t; push(x, K_DATA, r);
        low = (s.l + 1 > ex(hd) + ex(s.dsu)) ? s.l + 1 : ex(hd) + ex(s.dsu);
        x = a + low * t; push(x, K_RISE, r);
        x += ov; push(x, K_SAMP, r);
        x += (s.h + 1) * t; push(x, K_FALL, r); push(x, K_DONE, r);
      end
      2: begin // R7 RESTART
        push(a, K_SREL, r); x = a + ex(s.rel) * t; push(x, K_RISE, r);
        x += ov + ex(s.ssu) * t; push(x, K_SLOW, r);
        x += ex(s.shd) * t; push(x, K_FALL, r); push(x, K_DONE, r);
      end
      default: begin // R8 STOP
        push(a, K_SLOW, r); x = a + (s.l + 1) * t; push(x, K_RISE, r);
        x += ov + ex(s.psu) * t; push(x, K_SREL, r); push(x, K_DONE, r);
      end
    endcase
    mode_hs = md; cmd = 2'(c); cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    if (flip) mode_hs = !md;
    if (poke) begin
      for (int i = 0; i < 3; i++) begin
        cmd = 2'(c ^ 3); cmd_valid = 1;
        chk(cmd_ready == 0, "R10 busy", int'(cmd_ready), 0);
        @(negedge clk);
      end
      cmd_valid = 0;
    end
    while (!cmd_ready) @(negedge clk);
  endtask

  // Monitor: turns output activity into events and compares with the queue.
  always @(negedge clk) if (mon_en) begin
    bit [6:0] k; ev_t e;
    k = {done_stb, prev_scl && !scl_o, !prev_scl && scl_o, sample_stb, data_stb,
         sda_rel_stb, sda_low_stb};
    prev_scl = scl_o;
    if (sample_stb) chk(scl_o == 1, "R11 sample with SCL high", int'(scl_o), 1);
    for (int i = 0; i < 7; i++) if (k[i]) begin
      if (q.size() == 0) chk(0, "R10 unexpected event kind", i, -1);
      else begin
        e = q.pop_front();
        chk(e.kind == i && e.cyc == cyc, e.req, cyc * 10 + i, e.cyc * 10 + e.kind);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    fs = '{div:1, shd:3, ssu:2, psu:2, dsu:1, l:4, h:4, rel:3};
    hs = '{div:0, shd:1, ssu:1, psu:1, dsu:1, l:2, h:1, rel:2};
    hd = 1; flt = 1; apply();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(scl_o == 1, "R1 scl", int'(scl_o), 1);
    chk(cmd_ready == 1, "R1 ready", int'(cmd_ready), 1);
    chk({sda_low_stb, sda_rel_stb, data_stb, sample_stb, done_stb} == 0, "R1 strobes",
        int'({sda_low_stb, sda_rel_stb, data_stb, sample_stb, done_stb}), 0);
    mon_en = 1;
    // Fast timing, full transfer; the second BIT is poked while busy.
    issue(0, 0, 0, 0, "R2 start");
    issue(1, 0, 0, 1, "R3 bit period");
    issue(1, 0, 0, 0, "R4 bit strobes");
    issue(2, 0, 0, 0, "R7 restart");
    issue(1, 0, 1, 0, "R9 mode latched");
    issue(3, 0, 0, 0, "R8 stop");
    // All counts zero.
    fs = '{div:0, shd:0, ssu:0, psu:0, dsu:0, l:0, h:0, rel:0};
    hd = 0; flt = 0; apply();
    issue(0, 0, 0, 0, "R5 zero start");
    issue(1, 0, 0, 0, "R5 zero bit");
    issue(2, 0, 0, 0, "R5 zero restart");
    issue(3, 0, 0, 0, "R5 zero stop");
    // Hold plus setup longer than SCL low.
    fs = '{div:2, shd:2, ssu:2, psu:2, dsu:4, l:3, h:2, rel:2};
    hd = 5; flt = 3; apply();
    issue(0, 0, 0, 0, "R2 start div2");
    issue(1, 0, 0, 0, "R6 stretch");
    issue(3, 0, 0, 0, "R8 stop div2");
    // Fast start, then high-speed timing.
    fs = '{div:3, shd:2, ssu:1, psu:1, dsu:1, l:2, h:2, rel:1};
    hd = 2; flt = 2; apply();
    issue(0, 0, 0, 0, "R9 fast first");
    issue(1, 1, 1, 0, "R9 hs bit");
    issue(2, 1, 0, 0, "R9 hs restart");
    issue(1, 1, 0, 0, "R9 hs bit2");
    issue(3, 1, 0, 0, "R9 hs stop");
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R2 all events seen", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule